// File: doc/BRIEF.md
# Frame Sync Regenerator and Aligner

This block makes an 8 kHz frame-sync pulse by dividing a high-speed output clock. The clock appears as a one-cycle enable, `tick`. A modulo counter advances on every tick and wraps once per 125 us frame. Because the pulse comes from that clock, its phase stays locked to it. Two slow sync inputs can be paired with the two main clock inputs. `sync_a` belongs to clock input 0 and `sync_b` to clock input 1. The index of the currently active clock input selects which sync is used.

When pairing is enabled, holding `realign_req` high causes the divider to restart on the next rising edge of the active sync. After that, the regenerated pulse coincides with the incoming frame boundary. Between realignments, the block measures each active sync edge against the divider phase. It raises a sticky alarm when an edge lands outside a tolerance window. With pairing disabled, all sync inputs are treated as plain clocks: the divider runs free and the alarm stays low.

The control state machine has three states:
- `ST_FREE`: pairing is off.
- `ST_TRACK`: pairing is on and the phase is being monitored.
- `ST_SEEK`: a realignment is pending.

The state transitions are:
- `FREE->TRACK` when `pair_en` is high.
- `TRACK->SEEK` when `realign_req` is high.
- `SEEK->TRACK` on an active sync edge.
- Any state goes to `FREE` when `pair_en` is low.

Top module: `fsync_regen`

## Requirements
- R1: After reset, `fs_pulse` and `align_alarm` are 0. With no restart, the first pulse appears in the tick period that follows the FRAME_TICKS-th tick after reset.
- R2: Without a restart, `fs_pulse` is high for exactly one tick period after every FRAME_TICKS-th tick, and low otherwise.
- R3: In a cycle where `tick` is 0, the divider count, `fs_pulse` and the stored sync history all hold their values.
- R4: The active sync is chosen only when `pair_en`=1. `act_sel`=0 selects `sync_a` and `act_sel`=1 selects `sync_b`. `act_sel`=2 or 3 selects no sync, so realignment never completes and no phase is measured.
- R5: A sync rising edge is detected on a tick where the sync is sampled high and was sampled low on the previous tick. While in `ST_SEEK`, the first active edge restarts the divider. `fs_pulse` is then high in the period that begins at that tick, and pulses follow every FRAME_TICKS ticks after it.
- R6: In `ST_TRACK`, each active edge is scored as follows. Let d be the count the divider advances to on that tick; d is 0 on the tick that starts a pulse. The error is min(d, FRAME_TICKS-d). If the error exceeds TOL_TICKS, `align_alarm` is set.
- R7: Once set, `align_alarm` stays high until one of two events clears it: a realigning edge in `ST_SEEK`, or `pair_en` going low.
- R8: With `pair_en`=0, `realign_req` and sync edges have no effect on `fs_pulse`, and `align_alarm` stays 0.
- R9: Edges on the sync input that is not selected neither restart the divider nor affect the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable, one per high-speed output clock period |
| sync_a | input | 1 | Frame sync paired with clock input 0 |
| sync_b | input | 1 | Frame sync paired with clock input 1 |
| act_sel | input | 2 | Index of the active clock input (0..3) |
| pair_en | input | 1 | Enables clock/sync pairing and alignment |
| realign_req | input | 1 | Level request to re-phase to the next active sync edge |
| fs_pulse | output | 1 | Regenerated frame-sync pulse, one tick wide |
| align_alarm | output | 1 | Sticky alarm: active sync outside tolerance |

## Verification
A wrong divider count shows up as a misplaced or missing `fs_pulse` within one frame of FRAME_TICKS ticks. A wrong FSM state shows up at the next active sync edge in one of three ways: a restart that should not occur, a restart that is missing, or an alarm that differs from the computed error. The bench uses a small frame and sweeps every phase offset of the sync edge against the divider for both sync inputs. It compares both outputs with an arithmetic model on every cycle, so any divergence appears within at most one frame.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_SEEK  = 2'd2
    } fsr_state_e;
endpackage

// File: rtl/fsr_edge.sv
// Per-input rising-edge detector sampled on the tick enable.
module fsr_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
            end else if (tick) begin
                prev_q[g] <= din[g];
            end
        end
        assign rise[g] = tick & din[g] & ~prev_q[g];
    end
endmodule

// File: rtl/fsr_divider.sv
// Frame divider: modulo-FRAME_TICKS counter with a registered one-tick pulse.
module fsr_divider #(
    parameter int FRAME_TICKS = 19440,
    parameter int CW          = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] nxt_o,
    output logic          pulse_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);

    assign nxt_o = (cnt_o == LAST) ? '0 : cnt_o + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            pulse_o <= 1'b0;
        end else if (tick) begin
            if (restart) begin
                cnt_o   <= '0;
                pulse_o <= 1'b1;
            end else begin
                cnt_o   <= nxt_o;
                pulse_o <= (nxt_o == '0);
            end
        end
    end
endmodule

// File: rtl/fsr_phase.sv
// Circular distance of the divider phase from the pulse position.
module fsr_phase #(
    parameter int FRAME_TICKS = 19440,
    parameter int CW          = 15,
    parameter int TOL_TICKS   = 4
) (
    input  logic [CW-1:0] nxt,
    output logic          out_of_tol
);
    localparam logic [CW:0] N_W    = (CW+1)'(FRAME_TICKS);
    localparam logic [CW:0] HALF_W = (CW+1)'(FRAME_TICKS / 2);
    localparam logic [CW:0] TOL_W  = (CW+1)'(TOL_TICKS);

    logic [CW:0] d_w;
    logic [CW:0] err_w;

    always_comb begin
        d_w        = {1'b0, nxt};
        err_w      = (d_w > HALF_W) ? (N_W - d_w) : d_w;
        out_of_tol = (err_w > TOL_W);
    end
endmodule

// File: rtl/fsync_regen.sv
module fsync_regen
    import fsr_pkg::*;
#(
    parameter int FRAME_TICKS = 19440,
    parameter int TOL_TICKS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sync_a,
    input  logic       sync_b,
    input  logic [1:0] act_sel,
    input  logic       pair_en,
    input  logic       realign_req,
    output logic       fs_pulse,
    output logic       align_alarm
);
    localparam int CW = (FRAME_TICKS > 2) ? $clog2(FRAME_TICKS) : 1;

    fsr_state_e    state, state_nxt;
    logic [1:0]    rise;
    logic          sel_rise;
    logic          restart;
    logic          out_of_tol;
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;

    fsr_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .din  ({sync_b, sync_a}),
        .rise (rise)
    );

    // Only clock inputs 0 and 1 carry a paired sync.
    assign sel_rise = pair_en & ~act_sel[1] & rise[act_sel[0]];
    assign restart  = pair_en & (state == ST_SEEK) & sel_rise;

    fsr_divider #(.FRAME_TICKS(FRAME_TICKS), .CW(CW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .restart(restart),
        .cnt_o  (cnt),
        .nxt_o  (nxt),
        .pulse_o(fs_pulse)
    );

    fsr_phase #(.FRAME_TICKS(FRAME_TICKS), .CW(CW), .TOL_TICKS(TOL_TICKS)) u_phase (
        .nxt       (nxt),
        .out_of_tol(out_of_tol)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FREE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (!pair_en) begin
            state_nxt = ST_FREE;
        end else begin
            unique case (state)
                ST_FREE:  state_nxt = ST_TRACK;
                ST_TRACK: if (realign_req) state_nxt = ST_SEEK;
                ST_SEEK:  if (sel_rise)    state_nxt = ST_TRACK;
                default:  state_nxt = ST_FREE;
            endcase
        end
    end

    // Output process: alignment alarm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_alarm <= 1'b0;
        end else if (!pair_en) begin
            align_alarm <= 1'b0;
        end else begin
            unique case (state)
                ST_FREE:  align_alarm <= 1'b0;
                ST_TRACK: if (sel_rise && out_of_tol) align_alarm <= 1'b1;
                ST_SEEK:  if (sel_rise) align_alarm <= 1'b0;
                default:  align_alarm <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fsync_regen_chk.sv
module fsync_regen_chk
    import fsr_pkg::*;
#(
    parameter int FRAME_TICKS = 19440,
    parameter int CW          = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          pair_en,
    input logic          fs_pulse,
    input logic          align_alarm,
    input fsr_state_e    state,
    input logic          restart,
    input logic [CW-1:0] cnt
);
    // R2: pulse lasts one tick unless a restart re-launches it
    a_r2_one_tick_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_pulse && tick && !restart && FRAME_TICKS > 1) |=> !fs_pulse);

    // R3: nothing advances without a tick
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(fs_pulse) && $stable(cnt)));

    // R5: a restart puts the pulse at the edge tick
    a_r5_restart_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> fs_pulse);

    // R6: alarm can only rise from phase tracking
    a_r6_alarm_from_track: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_alarm) |-> ($past(state) == ST_TRACK));

    // R7: alarm is sticky while paired and not realigning
    a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (align_alarm && pair_en && !restart) |=> align_alarm);

    // R8: pairing off forces the alarm low
    a_r8_free_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_en |=> !align_alarm);
endmodule

bind fsync_regen fsync_regen_chk #(.FRAME_TICKS(FRAME_TICKS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pair_en    (pair_en),
    .fs_pulse   (fs_pulse),
    .align_alarm(align_alarm),
    .state      (state),
    .restart    (restart),
    .cnt        (cnt)
);

// File: tb/fsync_regen_tb_top.sv
`timescale 1ns/1ps
module fsync_regen_tb_top;
    localparam int N   = 12;
    localparam int TOL = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       sync_a = 1'b0;
    logic       sync_b = 1'b0;
    logic [1:0] act_sel = 2'd0;
    logic       pair_en = 1'b0;
    logic       realign_req = 1'b0;
    logic       fs_pulse;
    logic       align_alarm;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Arithmetic model state (0 free, 1 track, 2 seek)
    int m_state = 0;
    int m_cnt   = 0;
    bit m_pulse = 0;
    bit m_alarm = 0;
    bit m_pa    = 0;
    bit m_pb    = 0;

    always #2 clk = ~clk;

    fsync_regen #(.FRAME_TICKS(N), .TOL_TICKS(TOL)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .sync_a     (sync_a),
        .sync_b     (sync_b),
        .act_sel    (act_sel),
        .pair_en    (pair_en),
        .realign_req(realign_req),
        .fs_pulse   (fs_pulse),
        .align_alarm(align_alarm)
    );

    task automatic check(input bit act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit t, input bit a, input bit b, input bit [1:0] s,
                        input bit pe, input bit rr, input string tag);
        bit ea, eb, se, rs;
        int d, err, ns;
        tick = t; sync_a = a; sync_b = b; act_sel = s; pair_en = pe; realign_req = rr;
        ea  = t & a & ~m_pa;
        eb  = t & b & ~m_pb;
        se  = pe && !s[1] && (s[0] ? eb : ea);
        d   = (m_cnt == N - 1) ? 0 : m_cnt + 1;
        err = (d > N / 2) ? N - d : d;
        rs  = pe && (m_state == 2) && se;
        if (!pe) ns = 0;
        else if (m_state == 0) ns = 1;
        else if (m_state == 1) ns = rr ? 2 : 1;
        else ns = se ? 1 : 2;
        if (!pe) m_alarm = 0;
        else if (m_state == 0) m_alarm = 0;
        else if (m_state == 1) begin if (se && err > TOL) m_alarm = 1; end
        else begin if (se) m_alarm = 0; end
        if (t) begin
            if (rs) begin m_cnt = 0; m_pulse = 1; end
            else begin m_cnt = d; m_pulse = (d == 0); end
            m_pa = a; m_pb = b;
        end
        m_state = ns;
        @(posedge clk);
        #1;
        check(fs_pulse, m_pulse, tag, "fs_pulse");
        check(align_alarm, m_alarm, tag, "align_alarm");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(fs_pulse, 1'b0, "R1", "reset fs_pulse");
        check(align_alarm, 1'b0, "R1", "reset align_alarm");
        rst_n = 1'b1;

        // R1 R2: free run, first pulse after N ticks
        for (int i = 0; i < 3 * N; i++) step(1, 0, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 2 * N; i++) step(1, 0, 0, 0, 0, 0, "R2");

        // R3: gaps in the tick enable, sync toggling during gaps
        for (int i = 0; i < 4 * N; i++)
            step((i % 3) != 0, (i % 7) == 1, 0, 0, 0, 0, "R3");

        // R8: pairing off, requests and edges ignored
        for (int i = 0; i < 3 * N; i++)
            step(1, (i % 5) == 0, (i % 4) == 0, i % 2, 0, 1, "R8");

        // R5 R6 R7 R9: sweep every phase offset for both sync inputs
        for (int sel = 0; sel < 2; sel++) begin
            for (int off = 0; off < N; off++) begin
                step(1, 0, 0, sel[1:0], 1, 1, "R5");
                step(1, 0, 0, sel[1:0], 1, 1, "R5");
                step(1, 0, 0, sel[1:0], 1, 0, "R5");
                step(1, sel == 0, sel == 1, sel[1:0], 1, 0, "R5");
                for (int k = 0; k < N - 1 + off; k++)
                    step(1, (sel == 1) && (k == 2), (sel == 0) && (k == 2),
                         sel[1:0], 1, 0, "R9");
                step(1, sel == 0, sel == 1, sel[1:0], 1, 0, "R6");
                for (int k = 0; k < N + 3; k++)
                    step(1, 0, 0, sel[1:0], 1, 0, "R7");
            end
        end

        // R4: act_sel 2 and 3 carry no sync, realign stays pending
        for (int s = 2; s < 4; s++) begin
            step(1, 0, 0, s[1:0], 1, 1, "R4");
            step(1, 0, 0, s[1:0], 1, 1, "R4");
            for (int k = 0; k < 2 * N; k++)
                step(1, (k % 5) == 0, (k % 5) == 0, s[1:0], 1, 0, "R4");
        end

        // R7: set alarm with a misplaced edge, then drop pairing
        step(1, 0, 0, 0, 1, 0, "R7");
        step(1, 1, 0, 0, 1, 0, "R7");
        for (int k = 0; k < N / 2; k++) step(1, 0, 0, 0, 1, 0, "R7");
        step(1, 1, 0, 0, 1, 0, "R7");
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 1, 0, "R7");
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, "R7");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule